// File: doc/BRIEF.md
# I2C Master Byte Count and Transfer End Controller

This block tracks the data phase of an I2C master transfer. Software programs a byte count. A START (or repeated START) loads that count into a down-counter. Each completed data byte strobes the counter down by one. When the count runs out, the block ends the transfer in one of three ways, chosen by two mode bits:

- **Reload:** raise a reload flag and hold SCL low until software supplies the next count.
- **Auto stop:** issue a STOP command on its own.
- **Software end:** raise a completion flag and hold SCL low until software issues a START or a STOP.

Software may also request a STOP at any time. The request is remembered. It takes effect only when the byte in flight completes, or at once if the bus is already being held. The request is forgotten only when a STOP is seen on the bus or the peripheral is disabled. Bit-level SCL/SDA sequencing is outside this block. The block only asks for SCL to be stretched and for a STOP to be generated.

Top module: `i2c_xfer_end_ctrl`

## Requirements
- R1: Out of reset all four outputs (`tcr_flag`, `tc_flag`, `scl_hold`, `gen_stop`) are 0.
- R2: An accepted `start_req` loads `cnt_val`. The terminal action appears one cycle after the `cnt_val`-th accepted `byte_done`, and no output changes after earlier bytes.
- R3: With `reload_mode`=1 at the terminal byte, `tcr_flag` and `scl_hold` go to 1 and no STOP is generated, whatever `auto_end` is.
- R4: With `reload_mode`=0 and `auto_end`=1 at the terminal byte, `gen_stop` is 1 for exactly one cycle and neither flag is raised.
- R5: With `reload_mode`=0 and `auto_end`=0 at the terminal byte, `tc_flag` and `scl_hold` go to 1 and no STOP is generated.
- R6: While `tcr_flag` is 1, a `cnt_load` with a nonzero `cnt_val` clears `tcr_flag` and `scl_hold` and starts a new run of `cnt_val` bytes. A `cnt_load` of zero is ignored.
- R7: While `tc_flag` is 1, `start_req` clears it (restart with a fresh count), and `stop_set` clears it and pulses `gen_stop` one cycle later.
- R8: `stop_set` during a transfer gives no STOP until the next `byte_done`. One cycle after that byte, `gen_stop` pulses. A pending stop takes precedence over a terminal action on the same byte, so no flag is raised.
- R9: A pending stop is cleared by `stop_seen` or by `enable`=0, after which bytes of a new transfer do not trigger `gen_stop`.
- R10: A `start_req` with `cnt_val`=0 makes the terminal action one cycle later, without any `byte_done`.
- R11: `enable`=0 forces all outputs to 0 at the next clock edge. `start_req` is ignored while disabled, and also while `tcr_flag` is 1.
- R12: `byte_done` has no effect while no transfer is active or while `scl_hold` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| enable | input | 1 | Peripheral enable; 0 flushes all state |
| cnt_val | input | 8 | Programmed byte count |
| cnt_load | input | 1 | Strobe: software wrote a new count |
| reload_mode | input | 1 | 1 = reload at terminal count |
| auto_end | input | 1 | 1 = automatic STOP at terminal count (reload off) |
| start_req | input | 1 | Strobe: START/restart with address phase done |
| byte_done | input | 1 | Strobe: one data byte completed |
| stop_set | input | 1 | Strobe: software STOP request |
| stop_seen | input | 1 | Strobe: STOP condition detected on the bus |
| tcr_flag | output | 1 | Count reached, awaiting reload |
| tc_flag | output | 1 | Transfer complete, awaiting START or STOP |
| scl_hold | output | 1 | Request to stretch SCL low |
| gen_stop | output | 1 | One-cycle command to issue a STOP |

## Verification
Each fault in the counter, flags or stop-pending state shows up at the ports within one cycle of the byte strobe that exposes it:

- **Off-by-one count:** the flag or STOP pulse moves by one cycle.
- **Lost pending stop:** `gen_stop` stays low after the next byte.
- **Stale pending stop:** a spurious STOP appears after the first byte of a later transfer.
- **Wrong mode decode:** the wrong one of the three outputs rises.

Directed sequences pin down each ending and each clear path. Seeded random traffic then compares all four outputs every cycle against a bench model built from the requirements.

// File: rtl/i2c_xe_pkg.sv
package i2c_xe_pkg;
  typedef enum logic [1:0] {
    END_SOFT   = 2'd0,
    END_AUTO   = 2'd1,
    END_RELOAD = 2'd2
  } end_kind_t;

  function automatic end_kind_t pick_end(input logic reload, input logic auto_e);
    if (reload)      return END_RELOAD;
    else if (auto_e) return END_AUTO;
    else             return END_SOFT;
  endfunction
endpackage

// File: rtl/xe_byte_counter.sv
module xe_byte_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] load_val,
  output logic             last_byte
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] rem_q, rem_d;

  always_comb begin
    rem_d = rem_q;
    if (clr)                      rem_d = '0;
    else if (load)                rem_d = load_val;
    else if (step && rem_q != '0) rem_d = rem_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  assign last_byte = step && (rem_q == ONE);

  // R2: a byte is only ever counted against a nonzero remainder
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |-> (rem_q != '0));
endmodule

// File: rtl/xe_stop_ctl.sv
module xe_stop_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic stop_set,
  input  logic stop_seen,
  input  logic active,
  input  logic held,
  input  logic byte_step,
  input  logic start_ok,
  output logic fire
);
  logic pend_q, pend_d, pend_eff;

  always_comb begin
    pend_d = pend_q;
    if (!enable || stop_seen) pend_d = 1'b0;
    else if (stop_set)        pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_eff = pend_q || (enable && stop_set);
  assign fire = enable && active && pend_eff && !start_ok && (byte_step || held);

  // R9: once the bus reports a STOP, nothing remains pending
  a_r9_seen_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !pend_q);
  // R8: a fire with no request in this cycle implies one is remembered
  a_r8_fire_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !stop_set) |-> pend_q);
endmodule

// File: rtl/xe_end_flags.sv
module xe_end_flags
  import i2c_xe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic terminal,
  input  logic reload_mode,
  input  logic auto_end,
  input  logic stop_fire,
  input  logic start_ok,
  input  logic reload_req,
  output logic tcr_q,
  output logic tc_q,
  output logic gen_q
);
  end_kind_t kind;
  logic      term_eff;
  logic      tcr_d, tc_d, gen_d;

  assign kind     = pick_end(reload_mode, auto_end);
  assign term_eff = terminal && !stop_fire;

  always_comb begin
    tcr_d = tcr_q;
    tc_d  = tc_q;
    gen_d = 1'b0;
    if (!enable) begin
      tcr_d = 1'b0;
      tc_d  = 1'b0;
    end else begin
      if (stop_fire || reload_req) tcr_d = 1'b0;
      if (stop_fire || start_ok)   tc_d  = 1'b0;
      if (stop_fire)               gen_d = 1'b1;
      if (term_eff) begin
        unique case (kind)
          END_RELOAD: tcr_d = 1'b1;
          END_AUTO:   gen_d = 1'b1;
          default:    tc_d  = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcr_q <= 1'b0;
      tc_q  <= 1'b0;
      gen_q <= 1'b0;
    end else begin
      tcr_q <= tcr_d;
      tc_q  <= tc_d;
      gen_q <= gen_d;
    end
  end

  // R3: reload flag only rises when reload mode was selected
  a_r3_tcr_needs_reload: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tcr_q) |-> $past(reload_mode));
  // R5: completion flag never rises in reload mode
  a_r5_tc_not_reload: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_q) |-> !$past(reload_mode));
  // R4: the STOP command is a single-cycle pulse
  a_r4_gen_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    gen_q |=> !gen_q);
  // R11: disable empties every flag at the next edge
  a_r11_disable_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!tcr_q && !tc_q && !gen_q));
  // R3 R5: the two end flags never coexist
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(tcr_q && tc_q));
endmodule

// File: rtl/i2c_xfer_end_ctrl.sv
module i2c_xfer_end_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_load,
  input  logic             reload_mode,
  input  logic             auto_end,
  input  logic             start_req,
  input  logic             byte_done,
  input  logic             stop_set,
  input  logic             stop_seen,
  output logic             tcr_flag,
  output logic             tc_flag,
  output logic             scl_hold,
  output logic             gen_stop
);
  logic active_q, active_d;
  logic held, start_ok, reload_req, byte_step, stop_fire;
  logic last_byte, terminal, zero_cnt;
  logic tcr_q, tc_q, gen_q;

  assign held       = tcr_q || tc_q;
  assign zero_cnt   = (cnt_val == '0);
  assign start_ok   = enable && start_req && !tcr_q;
  assign reload_req = enable && tcr_q && cnt_load && !zero_cnt;
  assign byte_step  = enable && active_q && !held && byte_done && !start_ok;
  assign terminal   = (start_ok && zero_cnt) || last_byte;

  xe_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (!enable),
    .load      (start_ok || reload_req),
    .step      (byte_step),
    .load_val  (cnt_val),
    .last_byte (last_byte)
  );

  xe_stop_ctl u_stop (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .stop_set  (stop_set),
    .stop_seen (stop_seen),
    .active    (active_q),
    .held      (held),
    .byte_step (byte_step),
    .start_ok  (start_ok),
    .fire      (stop_fire)
  );

  xe_end_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .terminal    (terminal),
    .reload_mode (reload_mode),
    .auto_end    (auto_end),
    .stop_fire   (stop_fire),
    .start_ok    (start_ok),
    .reload_req  (reload_req),
    .tcr_q       (tcr_q),
    .tc_q        (tc_q),
    .gen_q       (gen_q)
  );

  always_comb begin
    active_d = active_q;
    if (!enable)                                               active_d = 1'b0;
    else if (stop_fire)                                        active_d = 1'b0;
    else if (terminal && !reload_mode && auto_end)             active_d = 1'b0;
    else if (start_ok)                                         active_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  assign tcr_flag = tcr_q;
  assign tc_flag  = tc_q;
  assign scl_hold = held;
  assign gen_stop = gen_q;

  // R12: stretching is only requested inside a live transfer
  a_r12_hold_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> active_q);
  // R4: an automatic or requested STOP ends the transfer
  a_r4_stop_ends_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    gen_stop |-> (!active_q && !scl_hold));
endmodule

// File: tb/tb_i2c_xfer_end_ctrl.sv
module tb_i2c_xfer_end_ctrl;
  logic       clk, rst_n, enable, cnt_load, reload_mode, auto_end;
  logic       start_req, byte_done, stop_set, stop_seen;
  logic [7:0] cnt_val;
  logic       tcr_flag, tc_flag, scl_hold, gen_stop;

  int n_checks = 0;
  int n_errs   = 0;

  // bench reference state
  logic [7:0] m_rem;
  logic       m_act, m_tcr, m_tc, m_gen, m_pend;

  i2c_xfer_end_ctrl dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cnt_val(cnt_val),
    .cnt_load(cnt_load), .reload_mode(reload_mode), .auto_end(auto_end),
    .start_req(start_req), .byte_done(byte_done), .stop_set(stop_set),
    .stop_seen(stop_seen), .tcr_flag(tcr_flag), .tc_flag(tc_flag),
    .scl_hold(scl_hold), .gen_stop(gen_stop)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rem = 0; m_act = 0; m_tcr = 0; m_tc = 0; m_gen = 0; m_pend = 0;
    end else begin : model
      logic held, st, rl, bs, fire, term, pend_now;
      held = m_tcr | m_tc;
      st   = enable & start_req & ~m_tcr;
      rl   = enable & m_tcr & cnt_load & (cnt_val != 0);
      bs   = enable & m_act & ~held & byte_done & ~st;
      pend_now = m_pend | (enable & stop_set);
      fire = enable & m_act & pend_now & ~st & (bs | held);
      term = ~fire & ((st & cnt_val == 0) | (bs & m_rem == 1));
      m_gen = 0;
      if (!enable) begin
        m_rem = 0; m_act = 0; m_tcr = 0; m_tc = 0; m_pend = 0;
      end else begin
        if (fire) begin m_tcr = 0; m_tc = 0; m_gen = 1; m_act = 0; end
        if (rl) begin m_tcr = 0; m_rem = cnt_val; end
        if (st) begin m_tc = 0; m_rem = cnt_val; m_act = 1; end
        if (bs && m_rem != 0) m_rem = m_rem - 1;
        if (term) begin
          if (reload_mode)   m_tcr = 1;
          else if (auto_end) begin m_gen = 1; m_act = 0; end
          else               m_tc = 1;
        end
        if (stop_seen)     m_pend = 0;
        else if (stop_set) m_pend = 1;
      end
    end
  end

  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {tcr_flag, tc_flag, scl_hold, gen_stop};
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: {tcr,tc,hold,gen} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_in();
    start_req = 0; byte_done = 0; stop_set = 0; stop_seen = 0; cnt_load = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle_in();
  endtask

  task automatic do_start(input logic [7:0] n);
    cnt_val = n; start_req = 1; tick();
  endtask

  task automatic do_byte(); byte_done = 1; tick(); endtask
  task automatic do_stop(); stop_set = 1; tick(); endtask
  task automatic do_seen(); stop_seen = 1; tick(); endtask

  initial begin
    #200000;
    n_errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; enable = 1; reload_mode = 0; auto_end = 0; cnt_val = 0;
    idle_in();
    repeat (3) @(posedge clk);
    #1 chk("R1", 4'b0000);
    rst_n = 1;
    tick(); chk("R1", 4'b0000);

    // R2 R4: auto stop after three bytes
    auto_end = 1; reload_mode = 0;
    do_start(3); chk("R2", 4'b0000);
    do_byte();   chk("R2", 4'b0000);
    do_byte();   chk("R2", 4'b0000);
    do_byte();   chk("R4", 4'b0001);
    tick();      chk("R4", 4'b0000);
    do_seen();

    // R5 R12 R7: software end
    auto_end = 0;
    do_start(2); do_byte(); do_byte(); chk("R5", 4'b0110);
    do_byte();   chk("R12", 4'b0110);
    do_start(2); chk("R7", 4'b0000);
    do_byte(); do_byte(); chk("R5", 4'b0110);
    do_stop();   chk("R7", 4'b0001);
    do_seen();   chk("R7", 4'b0000);
    do_byte();   chk("R12", 4'b0000);

    // R3 R6: reload, auto_end ignored
    reload_mode = 1; auto_end = 1;
    do_start(2); do_byte(); do_byte(); chk("R3", 4'b1010);
    cnt_val = 0; cnt_load = 1; tick(); chk("R6", 4'b1010);
    start_req = 1; cnt_val = 3; tick(); chk("R11", 4'b1010);
    reload_mode = 0; auto_end = 0;
    cnt_val = 4; cnt_load = 1; tick(); chk("R6", 4'b0000);
    do_byte(); do_byte(); do_byte(); chk("R6", 4'b0000);
    do_byte(); chk("R6", 4'b0110);
    do_stop(); chk("R7", 4'b0001);
    do_seen();

    // R8: sticky stop waits for byte; wins over terminal
    do_start(5); do_stop(); chk("R8", 4'b0000);
    do_byte();   chk("R8", 4'b0001);
    tick();      chk("R8", 4'b0000);
    do_seen();
    do_start(1); do_stop(); do_byte(); chk("R8", 4'b0001);
    do_seen();
    // R9: cleared pending does not fire later
    do_start(2); do_byte(); chk("R9", 4'b0000);
    do_byte(); chk("R9", 4'b0110);
    do_stop(); do_seen();
    do_start(3); do_stop(); enable = 0; tick(); enable = 1; tick();
    do_start(1); do_byte(); chk("R9", 4'b0110);

    // R10 R11: zero count, then disable
    do_start(0); chk("R10", 4'b0110);
    enable = 0; tick(); chk("R11", 4'b0000);
    do_start(0); chk("R11", 4'b0000);
    enable = 1; tick();
    auto_end = 1; do_start(0); chk("R10", 4'b0001);
    do_seen();

    // random traffic checked against bench model
    for (int i = 0; i < 4000; i++) begin
      enable      = ($urandom_range(99) > 2);
      start_req   = ($urandom_range(99) < 6);
      byte_done   = ($urandom_range(99) < 35);
      stop_set    = ($urandom_range(99) < 3);
      stop_seen   = ($urandom_range(99) < 5);
      cnt_load    = ($urandom_range(99) < 10);
      cnt_val     = 8'($urandom_range(5));
      if ($urandom_range(99) < 5) reload_mode = $urandom_range(1);
      if ($urandom_range(99) < 5) auto_end    = $urandom_range(1);
      @(posedge clk); #1;
      // R2 R3 R4 R5 R6 R8 R11 R12 under random mix
      chk("R2", {m_tcr, m_tc, m_tcr | m_tc, m_gen});
    end

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule